// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block sits between a simple host request port and a single-data-rate synchronous DRAM with two banks and a 16-bit data bus. The host offers one word at a time, either a read or a write. Each request carries a flag that asks for the bank to be closed automatically once the access is done. The controller turns each request into the chip-select, row-strobe, column-strobe and write-enable command sequence, with the matching address bus values, and returns read data on a response port.

After reset the controller waits through a power-up interval. It then closes both banks and loads the mode register. Only after that does it offer ready to the host. The controller remembers the open row of each bank, so a request to an already open row goes straight to the column command. An internal timer requests an auto-refresh at a fixed interval. A pending refresh is served as soon as the access in progress completes: any open bank is closed first, and host requests are held off until the refresh wait has passed. All timing limits are compile-time cycle counts.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: The command on {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} is encoded as follows: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, idle 0111. Reset leaves the idle code on the pins with the data output enable low.
- R2: After reset, host_ready stays low until three things have happened in order: at least PWRUP_CYC cycles pass, a precharge with mem_addr[10] high is issued, and a mode load is issued. The mode load word carries CAS_LAT in mem_addr[6:4] and zeros elsewhere, which selects a burst of one.
- R3: host_addr is {bank[21], row[20:10], col[9:0]}. An activate drives the bank on mem_addr[11] and the row on mem_addr[10:0]. A read or write drives the bank on mem_addr[11], the column on mem_addr[9:0] and the host auto-close flag on mem_addr[10].
- R4: A request to a bank whose open row matches issues no activate and no precharge. A request to a bank that has a different row open issues a precharge with mem_addr[10] low, then an activate. A request to a closed bank issues only an activate.
- R5: The spacing between commands is never below the following limits: activate to column command of that bank T_RCD, precharge to the next command of that bank T_RP, mode load to any command T_MCD, refresh to any command T_RC, and last write to the precharge of that bank T_DPL.
- R6: For a write, the data word is on mem_dq_out with mem_dq_oe high in the same cycle as the write command. mem_dq_oe is low in every other cycle.
- R7: For each read, rsp_valid pulses for one cycle exactly CAS_LAT+1 cycles after the read command cycle. rsp_data carries the word sampled from mem_dq_in, and responses come back in request order.
- R8: A refresh is requested every REFRESH_INTERVAL cycles. It is issued after the access in progress completes, so the gap between refresh commands never exceeds REFRESH_INTERVAL plus one access time.
- R9: Refresh and mode load commands are issued only while both banks are closed. Open banks are closed by a precharge with mem_addr[10] high before a refresh.
- R10: A read or write that carries the auto-close flag leaves its bank closed, so the next access to that bank begins with an activate even for the same row.
- R11: Data written to an address is what a later read of that address returns, across both banks, row changes and refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller accepts a request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_autopre | input | 1 | Close the bank after this access |
| host_addr | input | 22 | {bank, row, column} |
| host_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 12 | Memory address bus |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
The hardest case to reach from the ports is a refresh that falls due while a bank still holds an open row. Only then must the controller insert a close-all precharge ahead of the refresh, and the next host request must reopen the row even though its tag still matches. The bench shortens the refresh interval and streams many requests without the auto-close flag, so banks are usually open when the timer fires. A bus-level memory model in the bench tracks the bank state and command spacing from the pins alone. It also counts activates and precharges per request against a shadow of the expected open rows, which must be reset whenever a refresh is observed.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IPRE, ST_IMRS, ST_IDLE, ST_LOOK, ST_ACT, ST_RW, ST_REF, ST_WAIT
  } fsm_e;

endpackage

// File: rtl/sdr_bank_table.sv
module sdr_bank_table
  import sdr_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11
) (
  input  logic                                clk,
  input  logic                                rst,
  input  sdr_cmd_e                            cmd,
  input  logic [$clog2(NUM_BANKS)+ROW_W-1:0]  addr,
  output logic [NUM_BANKS-1:0]                bank_open,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ABUS_W = BANK_W + ROW_W;
  localparam int AP_BIT = ROW_W - 1;

  logic [BANK_W-1:0] cbank;
  logic              is_col;
  assign cbank  = addr[ABUS_W-1 -: BANK_W];
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             sel;
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    assign sel = (cbank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (cmd == CMD_ACT && sel) begin
        open_q <= 1'b1;
        row_q  <= addr[ROW_W-1:0];
      end else if (cmd == CMD_PRE && (addr[AP_BIT] || sel)) begin
        open_q <= 1'b0;
      end else if (is_col && sel && addr[AP_BIT]) begin
        open_q <= 1'b0;
      end
    end

    assign bank_open[b] = open_q;
    assign open_row[b]  = row_q;

    // R4: a row is only opened in a closed bank
    a_r4_act_on_closed: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_ACT && sel) |-> !open_q);
    // R10: column commands only reach an open bank
    a_r10_col_on_open: assert property (@(posedge clk) disable iff (rst)
      (is_col && sel) |-> open_q);
  end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic served,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;
  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)        pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end

  // R8: the interval counter wraps at the programmed value
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(INTERVAL));
  // R8: every interval expiry leaves a request behind
  a_r8_tick_sets: assert property (@(posedge clk) disable iff (rst)
    tick |=> pending);

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int LAT    = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [LAT-1:0] sh;

  if (LAT > 1) begin : g_multi
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[LAT-2:0], issue};
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= issue;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sh[LAT-1];
      if (sh[LAT-1]) rsp_data <= dq_in;
    end
  end

endmodule

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl
  import sdr_ctrl_pkg::*;
#(
  parameter int DATA_W           = 16,
  parameter int NUM_BANKS        = 2,
  parameter int COL_W            = 10,
  parameter int CAS_LAT          = 2,
  parameter int T_RCD            = 2,
  parameter int T_RP             = 2,
  parameter int T_RC             = 6,
  parameter int T_MCD            = 2,
  parameter int T_DPL            = 2,
  parameter int PWRUP_CYC        = 10000,
  parameter int REFRESH_INTERVAL = 780
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           host_valid,
  output logic                                           host_ready,
  input  logic                                           host_write,
  input  logic                                           host_autopre,
  input  logic [$clog2(NUM_BANKS)+2*COL_W:0]             host_addr,
  input  logic [DATA_W-1:0]                              host_wdata,
  output logic                                           rsp_valid,
  output logic [DATA_W-1:0]                              rsp_data,
  output logic                                           mem_cs_n,
  output logic                                           mem_ras_n,
  output logic                                           mem_cas_n,
  output logic                                           mem_we_n,
  output logic [$clog2(NUM_BANKS)+COL_W:0]               mem_addr,
  output logic [DATA_W-1:0]                              mem_dq_out,
  output logic                                           mem_dq_oe,
  input  logic [DATA_W-1:0]                              mem_dq_in
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int ROW_W   = COL_W + 1;
  localparam int ABUS_W  = BANK_W + ROW_W;
  localparam int HADDR_W = BANK_W + ROW_W + COL_W;
  localparam int CNT_W   = $clog2(PWRUP_CYC + T_RC + T_RP + T_DPL + CAS_LAT + T_MCD + T_RCD + 2);
  localparam logic [ABUS_W-1:0] MODE_WORD = ABUS_W'({3'(CAS_LAT), 4'b0000});

  fsm_e              st, ret;
  logic [CNT_W-1:0]  cnt;
  sdr_cmd_e          cmd_q;
  logic [ABUS_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q;

  logic              req_we, req_ap;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [DATA_W-1:0] req_data;

  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
  logic                            ref_pend;
  logic                            any_open, req_hit;

  assign any_open   = |bank_open;
  assign req_hit    = bank_open[req_bank] && (open_row[req_bank] == req_row);
  assign host_ready = (st == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_PWR;
      ret      <= ST_IDLE;
      cnt      <= CNT_W'(PWRUP_CYC - 1);
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      dq_q     <= '0;
      oe_q     <= 1'b0;
      req_we   <= 1'b0;
      req_ap   <= 1'b0;
      req_bank <= '0;
      req_row  <= '0;
      req_col  <= '0;
      req_data <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      case (st)
        ST_PWR: begin
          if (cnt == '0) st <= ST_IPRE;
          else           cnt <= cnt - 1'b1;
        end
        ST_IPRE: begin
          cmd_q  <= CMD_PRE;
          addr_q <= {{BANK_W{1'b0}}, 1'b1, {COL_W{1'b0}}};
          cnt    <= CNT_W'(T_RP - 1);
          ret    <= ST_IMRS;
          st     <= ST_WAIT;
        end
        ST_IMRS: begin
          cmd_q  <= CMD_MRS;
          addr_q <= MODE_WORD;
          cnt    <= CNT_W'(T_MCD - 1);
          ret    <= ST_IDLE;
          st     <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            if (any_open) begin
              cmd_q  <= CMD_PRE;
              addr_q <= {{BANK_W{1'b0}}, 1'b1, {COL_W{1'b0}}};
              cnt    <= CNT_W'(T_RP - 1);
              ret    <= ST_REF;
              st     <= ST_WAIT;
            end else begin
              st <= ST_REF;
            end
          end else if (host_valid) begin
            req_we   <= host_write;
            req_ap   <= host_autopre;
            req_bank <= host_addr[HADDR_W-1 -: BANK_W];
            req_row  <= host_addr[COL_W +: ROW_W];
            req_col  <= host_addr[COL_W-1:0];
            req_data <= host_wdata;
            st       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (req_hit) begin
            st <= ST_RW;
          end else if (bank_open[req_bank]) begin
            cmd_q  <= CMD_PRE;
            addr_q <= {req_bank, 1'b0, {COL_W{1'b0}}};
            cnt    <= CNT_W'(T_RP - 1);
            ret    <= ST_ACT;
            st     <= ST_WAIT;
          end else begin
            st <= ST_ACT;
          end
        end
        ST_ACT: begin
          cmd_q  <= CMD_ACT;
          addr_q <= {req_bank, req_row};
          cnt    <= CNT_W'(T_RCD - 1);
          ret    <= ST_RW;
          st     <= ST_WAIT;
        end
        ST_RW: begin
          cmd_q  <= req_we ? CMD_WR : CMD_RD;
          addr_q <= {req_bank, req_ap, req_col};
          if (req_we) begin
            dq_q <= req_data;
            oe_q <= 1'b1;
            cnt  <= CNT_W'((req_ap ? T_DPL + T_RP : T_DPL) - 1);
          end else begin
            cnt  <= CNT_W'((req_ap ? T_RP + CAS_LAT : CAS_LAT) - 1);
          end
          ret <= ST_IDLE;
          st  <= ST_WAIT;
        end
        ST_REF: begin
          cmd_q <= CMD_REF;
          cnt   <= CNT_W'(T_RC - 1);
          ret   <= ST_IDLE;
          st    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) st <= ret;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = oe_q;

  sdr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_q),
    .addr      (addr_q),
    .bank_open (bank_open),
    .open_row  (open_row)
  );

  sdr_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .served  (cmd_q == CMD_REF),
    .pending (ref_pend)
  );

  sdr_rd_pipe #(.LAT(CAS_LAT), .DATA_W(DATA_W)) u_rdpipe (
    .clk       (clk),
    .rst       (rst),
    .issue     (cmd_q == CMD_RD),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R9: refresh only with every bank closed
  a_r9_ref_all_closed: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF) |-> (bank_open == '0));
  // R9: mode load only with every bank closed
  a_r9_mrs_all_closed: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (bank_open == '0));
  // R6: the data bus is driven only alongside a write command
  a_r6_oe_with_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (cmd_q == CMD_WR));

endmodule

// File: tb/sim_sdr_cmd_ctrl.sv
module sim_sdr_cmd_ctrl;
  localparam int CL   = 2;
  localparam int TRCD = 2;
  localparam int TRP  = 2;
  localparam int TRC  = 6;
  localparam int TMCD = 2;
  localparam int TDPL = 2;
  localparam int PWR  = 20;
  localparam int REFI = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_write = 1'b0, host_autopre = 1'b0;
  logic [21:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [11:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = '0;

  always #10 clk = ~clk;

  sdr_cmd_ctrl #(
    .CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_MCD(TMCD),
    .T_DPL(TDPL), .PWRUP_CYC(PWR), .REFRESH_INTERVAL(REFI)
  ) u0 (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_autopre(host_autopre), .host_addr(host_addr),
    .host_wdata(host_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- bus-level memory model ----------------
  int cyc = 0;
  int t_ref = -1000, t_mrs = -1000, last_ref = 0;
  int t_act[2], t_pre[2], t_wr[2];
  bit mopen[2];
  logic [10:0] mrow[2];
  int n_act = 0, n_pre = 0, n_pall = 0, n_ref = 0, n_mrs = 0, n_rw = 0;
  int first_pre_cyc = -1, mrs_cyc = -1;
  logic [11:0] mrs_val;
  bit last_act_b; logic [10:0] last_act_r;
  bit last_rw_b, last_rw_ap; logic [9:0] last_rw_c;
  logic [15:0] mdata [int];
  logic [15:0] pd [0:CL];
  int rd_t_q[$];
  logic [15:0] exp_q[$];

  initial begin
    for (int i = 0; i < 2; i++) begin
      t_act[i] = -1000; t_pre[i] = -1000; t_wr[i] = -1000; mopen[i] = 0; mrow[i] = '0;
    end
  end

  always @(negedge clk) begin
    logic [3:0] cmd;
    bit b, a10;
    int key;
    cyc++;
    cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    b   = mem_addr[11];
    a10 = mem_addr[10];
    if (!rst) begin
      if (host_ready && n_mrs == 0) chk(0, "R2 ready before mode load", 1, 0);
      if (mem_dq_oe && cmd != 4'b0100) chk(0, "R6 oe outside write", cmd, 4);
      if (cmd != 4'b0111) begin
        chk(cyc - t_ref >= TRC, "R5 refresh spacing", cyc - t_ref, TRC);
        chk(cyc - t_mrs >= TMCD, "R5 mode spacing", cyc - t_mrs, TMCD);
      end
      case (cmd)
        4'b0000: begin
          chk(!mopen[0] && !mopen[1], "R9 mode with open bank", {mopen[1], mopen[0]}, 0);
          n_mrs++; t_mrs = cyc; mrs_val = mem_addr; mrs_cyc = cyc; last_ref = cyc;
        end
        4'b0001: begin
          chk(!mopen[0] && !mopen[1], "R9 refresh with open bank", {mopen[1], mopen[0]}, 0);
          chk(cyc - t_pre[0] >= TRP && cyc - t_pre[1] >= TRP, "R5 precharge to refresh", cyc, 0);
          chk(cyc - last_ref <= REFI + 40, "R8 refresh gap", cyc - last_ref, REFI);
          n_ref++; t_ref = cyc; last_ref = cyc;
        end
        4'b0010: begin
          n_pre++;
          if (first_pre_cyc < 0) first_pre_cyc = cyc;
          for (int i = 0; i < 2; i++)
            if (a10 || b == i[0]) begin
              if (mopen[i]) chk(cyc - t_wr[i] >= TDPL, "R5 write recovery", cyc - t_wr[i], TDPL);
              mopen[i] = 0; t_pre[i] = cyc;
            end
          if (a10) n_pall++;
        end
        4'b0011: begin
          chk(!mopen[b], "R4 activate on open bank", 1, 0);
          chk(cyc - t_pre[b] >= TRP, "R5 precharge to activate", cyc - t_pre[b], TRP);
          mopen[b] = 1; mrow[b] = mem_addr[10:0]; t_act[b] = cyc;
          last_act_b = b; last_act_r = mem_addr[10:0]; n_act++;
        end
        4'b0100, 4'b0101: begin
          chk(mopen[b], "R10 column command to closed bank", 0, 1);
          chk(cyc - t_act[b] >= TRCD, "R5 activate to column", cyc - t_act[b], TRCD);
          key = int'({b, mrow[b], mem_addr[9:0]});
          if (cmd == 4'b0100) begin
            chk(mem_dq_oe == 1'b1, "R6 oe with write", mem_dq_oe, 1);
            mdata[key] = mem_dq_out;
            t_wr[b] = cyc;
            if (a10) begin mopen[b] = 0; t_pre[b] = cyc + TDPL; end
          end else begin
            rd_t_q.push_back(cyc);
            if (a10) begin mopen[b] = 0; t_pre[b] = cyc + CL; end
          end
          last_rw_b = b; last_rw_c = mem_addr[9:0]; last_rw_ap = a10; n_rw++;
        end
        4'b0111: ;
        default: chk(0, "R1 unknown command code", cmd, 7);
      endcase
    end
    // read data pipe: word appears on dq_in CL cycles after the read
    for (int i = CL; i > 0; i--) pd[i] = pd[i-1];
    pd[0] = 16'h0;
    if (!rst && cmd == 4'b0101) begin
      key = int'({b, mrow[b], mem_addr[9:0]});
      pd[0] = mdata.exists(key) ? mdata[key] : 16'h0;
    end
    mem_dq_in = pd[CL];
    // scoreboard monitor
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0 || rd_t_q.size() == 0) begin
        chk(0, "R7 unexpected response", rsp_data, 0);
      end else begin
        int tr; logic [15:0] e;
        tr = rd_t_q.pop_front();
        e  = exp_q.pop_front();
        chk(cyc - tr == CL + 1, "R7 response latency", cyc - tr, CL + 1);
        chk(rsp_data == e, "R11 read data", rsp_data, e);
      end
    end
  end

  // ---------------- driver ----------------
  logic [15:0] shadow [int];
  bit          exp_open[2];
  logic [10:0] exp_row[2];
  int          seen_ref = 0;

  task automatic do_req(input bit we, input bit ap, input bit b, input logic [10:0] r,
                        input logic [9:0] c, input logic [15:0] d);
    int a0, p0, w0, key;
    bit hit, miss_open;
    key = int'({b, r, c});
    @(negedge clk);
    host_valid = 1; host_write = we; host_autopre = ap;
    host_addr = {b, r, c}; host_wdata = d;
    while (!host_ready) @(negedge clk);
    if (n_ref != seen_ref) begin exp_open[0] = 0; exp_open[1] = 0; seen_ref = n_ref; end
    a0 = n_act; p0 = n_pre; w0 = n_rw;
    hit = exp_open[b] && exp_row[b] == r;
    miss_open = exp_open[b] && !hit;
    if (!we) exp_q.push_back(shadow.exists(key) ? shadow[key] : 16'h0);
    else     shadow[key] = d;
    @(negedge clk);
    host_valid = 0;
    while (n_rw == w0) @(negedge clk);
    chk(last_rw_b == b, "R3 column bank", last_rw_b, b);
    chk(last_rw_c == c, "R3 column address", last_rw_c, c);
    chk(last_rw_ap == ap, "R3 auto-close flag on A10", last_rw_ap, ap);
    chk(n_act - a0 == (hit ? 0 : 1), "R4 activate count", n_act - a0, hit ? 0 : 1);
    chk(n_pre - p0 == (miss_open ? 1 : 0), "R4 precharge count", n_pre - p0, miss_open ? 1 : 0);
    if (!hit) begin
      chk(last_act_b == b, "R3 activate bank", last_act_b, b);
      chk(last_act_r == r, "R3 activate row", last_act_r, r);
    end
    exp_open[b] = !ap; exp_row[b] = r;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    int unsigned seed;
    int ref0;
    exp_open[0] = 0; exp_open[1] = 0;
    exp_row[0] = '0; exp_row[1] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R1 idle code in reset",
        {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(mem_dq_oe == 0, "R1 oe low in reset", mem_dq_oe, 0);
    chk(host_ready == 0, "R2 ready low in reset", host_ready, 0);
    rst = 0;

    // R2: initialization sequence
    while (!host_ready) @(negedge clk);
    chk(n_mrs == 1, "R2 one mode load", n_mrs, 1);
    chk(n_pall == 1, "R2 close-all before mode load", n_pall, 1);
    chk(first_pre_cyc < mrs_cyc, "R2 precharge precedes mode load", first_pre_cyc, mrs_cyc);
    chk(first_pre_cyc - 4 >= PWR, "R2 power-up wait", first_pre_cyc - 4, PWR);
    chk(mrs_val == {5'b0, 3'(CL), 4'b0}, "R2 mode word", mrs_val, {5'b0, 3'(CL), 4'b0});

    // R4/R11: closed bank, then row hit, then row miss
    do_req(1, 0, 0, 11'd5, 10'd3, 16'hA5A5);
    do_req(0, 0, 0, 11'd5, 10'd3, 16'h0);
    do_req(1, 0, 0, 11'd5, 10'd9, 16'h1234);
    do_req(1, 0, 0, 11'd700, 10'd9, 16'h5678);
    do_req(0, 0, 0, 11'd5, 10'd9, 16'h0);
    // R10: auto-close then same row again
    do_req(1, 1, 1, 11'd2047, 10'd1023, 16'hBEEF);
    do_req(0, 1, 1, 11'd2047, 10'd1023, 16'h0);
    do_req(0, 0, 1, 11'd2047, 10'd1023, 16'h0);

    // R8/R9/R11: mixed traffic leaving rows open across refreshes
    seed = 32'h1357;
    ref0 = n_ref;
    for (int i = 0; i < 60; i++) begin
      bit we, ap, bb; logic [10:0] rr; logic [9:0] cc;
      seed = seed * 1103515245 + 12345;
      we = seed[16]; ap = (seed[20:18] == 3'd0); bb = seed[17];
      rr = 11'(seed[22:21]); cc = 10'(seed[25:23]);
      do_req(we, ap, bb, rr, cc, 16'(seed >> 8));
      repeat (seed[28:26]) @(negedge clk);
    end
    // R8: idle long enough for several refresh intervals
    repeat (3 * REFI) @(negedge clk);
    chk(n_ref - ref0 >= 3, "R8 refresh count", n_ref - ref0, 3);
    chk(n_pall >= 2, "R9 close-all before refresh", n_pall, 2);
    // R11: data survives refresh
    do_req(0, 0, 0, 11'd700, 10'd9, 16'h0);
    do_req(0, 0, 1, 11'd2047, 10'd1023, 16'h0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all responses returned", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule